// File: doc/BRIEF.md
# Ultra DMA Device-Side Burst Engine

This block sits at the device end of a parallel-ATA Ultra DMA data path. It runs on a fast internal clock that oversamples the host's control lines. It asks the host for a transfer, waits for the host's acknowledge, and then moves 16-bit words in one of two directions. In a receive burst the host writes data and the block captures one word on every rising edge and every falling edge of the host's strobe. The captured words go into a small receive FIFO. In a send burst the block takes words from a transmit FIFO and drives them onto the bus. It marks each word by toggling its own strobe, and does so only while the host signals that it is ready.

The core side controls the block with two level inputs. One says the core wants to receive host data and the other says it wants to send data. The block reports the end of each burst with a one-cycle done pulse that carries the number of words moved. The host can pause a burst by holding its strobe still or by withdrawing its ready line, and it ends a burst with its stop line. The block pauses a receive burst on its own when the receive FIFO fills up to a set margin.

Top module: `udma_burst_engine`

## Requirements
- R1: After reset, `dev_req`, `burst_done`, `bus_oe` and `rx_avail` are 0, and `tx_full` is 0.
- R2: `dev_req` rises only when `want_rx` is high and the receive FIFO is not full, or when `want_tx` is high and the transmit FIFO holds at least one word. With neither condition true it stays 0.
- R3: A burst begins only when `host_ack_n` is low and `host_stop` is low. While `host_stop` is high the block stays in its request phase and captures no words on strobe edges.
- R4: In a receive burst, each rising edge and each falling edge of `host_strobe` stores the word on `bus_in` into the receive FIFO, and the core reads the words back in arrival order.
- R5: When `host_strobe` stops toggling during a receive burst, no words are stored. The burst stays open: `dev_req` remains 1 and no done pulse occurs until edges resume.
- R6: Raising `host_stop` during a burst ends it. `burst_done` pulses high for exactly one cycle with `burst_words` equal to the words moved in that burst, and `dev_req` then goes to 0.
- R7: In a send burst, `bus_oe` is 1. Each word leaves the transmit FIFO in order onto `bus_out`, and `dev_strobe` toggles once per word, only while `host_ready_n` is low. While `host_ready_n` is high, `dev_strobe` and `bus_out` hold their values.
- R8: During a receive burst, `dev_req` drops to 0 once the receive FIFO holds DEPTH-MARGIN words (6 with defaults). Strobe edges that arrive when the FIFO is full are discarded. After the burst ends, `dev_req` stays 0 until at least one slot is free.
- R9: A send burst ends by itself when the transmit FIFO runs empty, with a done pulse that reports the word count.
- R10: Reset during a burst returns the block to idle with `dev_req` at 0 and both FIFOs emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| want_rx | input | 1 | Core is ready to receive host data |
| want_tx | input | 1 | Core has data to send to the host |
| rx_pop | input | 1 | Core takes the head word of the receive FIFO |
| rx_data | output | 16 | Head word of the receive FIFO |
| rx_avail | output | 1 | Receive FIFO is not empty |
| tx_push | input | 1 | Core writes a word into the transmit FIFO |
| tx_wdata | input | 16 | Word to write into the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO is full |
| host_ack_n | input | 1 | Host acknowledge of the request, active low |
| host_stop | input | 1 | Host request to end the burst |
| host_strobe | input | 1 | Host data strobe for receive bursts, both edges count |
| host_ready_n | input | 1 | Host ready for send-burst data, active low |
| bus_in | input | 16 | Data bus value driven by the host |
| bus_out | output | 16 | Data bus value driven by the device |
| bus_oe | output | 1 | Device drives the data bus |
| dev_strobe | output | 1 | Device data strobe, toggles once per sent word |
| dev_req | output | 1 | Device request for a DMA transfer |
| burst_done | output | 1 | One-cycle pulse at the end of a burst |
| burst_words | output | 16 | Word count of the burst just ended, valid with burst_done |

## Verification
A state machine stuck in the wrong phase shows on `dev_req` and `bus_oe` within a few cycles of the synchroniser delay. It shows as a request that never drops after a stop, a request that stays high while the receive FIFO is nearly full, or an output enable that is high during a receive burst. Faulty edge detection or a faulty FIFO pointer cannot be seen until the core reads the words back. There it appears as a missing, doubled or reordered word, or as a `burst_words` count at the done pulse that does not match the edges sent. A broken pause shows as `dev_strobe` toggling while the host's ready line is negated, and this is visible within three clocks of the negation.

// File: rtl/udma_pkg.sv
package udma_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_ACTIVE_OUT,
        ST_ACTIVE_IN,
        ST_PAUSED,
        ST_TERMINATE
    } burst_state_e;

    // Host control lines after synchronisation, packed for a single synchroniser
    typedef struct packed {
        logic ack_n;
        logic stop;
        logic strobe;
        logic ready_n;
    } host_ctl_t;

    localparam host_ctl_t CTL_RESET = '{ack_n: 1'b1, stop: 1'b0, strobe: 1'b0, ready_n: 1'b1};

    function automatic logic level_reached(input int unsigned level, input int unsigned limit);
        return level >= limit;
    endfunction

endpackage

// File: rtl/udma_sync.sv
module udma_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/udma_fifo.sv
module udma_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) push |-> !full);  // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);  // R9
endmodule

// File: rtl/udma_burst_engine.sv
module udma_burst_engine
    import udma_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int MARGIN = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              want_rx,
    input  logic              want_tx,
    input  logic              rx_pop,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_avail,
    input  logic              tx_push,
    input  logic [WORD_W-1:0] tx_wdata,
    output logic              tx_full,
    input  logic              host_ack_n,
    input  logic              host_stop,
    input  logic              host_strobe,
    input  logic              host_ready_n,
    input  logic [WORD_W-1:0] bus_in,
    output logic [WORD_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              dev_strobe,
    output logic              dev_req,
    output logic              burst_done,
    output logic [CNT_W-1:0]  burst_words
);
    localparam int CW        = $clog2(DEPTH+1);
    localparam int NEAR_MARK = DEPTH - MARGIN;

    burst_state_e st, st_nxt;
    logic         dir_in, dir_in_nxt;
    host_ctl_t    ctl_raw, ctl_s;
    word_t        bus_s;
    logic         strobe_prev, strobe_edge;
    logic [CNT_W-1:0] words;

    logic          rx_push, rx_full, rx_empty, rx_near;
    logic [CW-1:0] rx_count;
    logic          tx_pop, tx_empty;
    logic [CW-1:0] tx_count;
    word_t         tx_rdata;
    logic          abort, out_go, in_go;

    // Control lines and data pass through equal-depth synchronisers so edge and word line up
    assign ctl_raw = '{ack_n: host_ack_n, stop: host_stop, strobe: host_strobe, ready_n: host_ready_n};

    udma_sync #(.W($bits(host_ctl_t)), .RST_VAL(CTL_RESET)) u_ctl_sync (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
    );

    udma_sync #(.W(WORD_W), .RST_VAL('0)) u_data_sync (
        .clk(clk), .rst(rst), .d(bus_in), .q(bus_s)
    );

    always_ff @(posedge clk) begin
        if (rst) strobe_prev <= 1'b0;
        else     strobe_prev <= ctl_s.strobe;
    end
    assign strobe_edge = ctl_s.strobe ^ strobe_prev;

    udma_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(bus_s), .pop(rx_pop),
        .rdata(rx_data), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    udma_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
        .rdata(tx_rdata), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    assign rx_avail = !rx_empty;
    assign rx_near  = level_reached(32'(rx_count), NEAR_MARK);
    assign abort    = ctl_s.stop || ctl_s.ack_n;
    assign out_go   = want_rx && !rx_full;
    assign in_go    = want_tx && !tx_empty;

    always_comb begin
        st_nxt     = st;
        dir_in_nxt = dir_in;
        case (st)
            ST_IDLE: begin
                if (out_go) begin
                    st_nxt     = ST_REQUEST;
                    dir_in_nxt = 1'b0;
                end else if (in_go) begin
                    st_nxt     = ST_REQUEST;
                    dir_in_nxt = 1'b1;
                end
            end
            ST_REQUEST: begin
                if (dir_in ? !in_go : !out_go)       st_nxt = ST_IDLE;
                else if (!ctl_s.ack_n && !ctl_s.stop) st_nxt = dir_in ? ST_ACTIVE_IN : ST_ACTIVE_OUT;
            end
            ST_ACTIVE_OUT: begin
                if (abort)        st_nxt = ST_TERMINATE;
                else if (rx_near) st_nxt = ST_PAUSED;
            end
            ST_ACTIVE_IN: begin
                if (abort)              st_nxt = ST_TERMINATE;
                else if (ctl_s.ready_n) st_nxt = ST_PAUSED;
                else if (tx_empty)      st_nxt = ST_TERMINATE;
            end
            ST_PAUSED: begin
                if (abort)                                  st_nxt = ST_TERMINATE;
                else if (dir_in && !ctl_s.ready_n)          st_nxt = ST_ACTIVE_IN;
                else if (!dir_in && !rx_near)               st_nxt = ST_ACTIVE_OUT;
            end
            ST_TERMINATE: st_nxt = ST_IDLE;
            default:      st_nxt = ST_IDLE;
        endcase
    end

    assign rx_push = (st == ST_ACTIVE_OUT || (st == ST_PAUSED && !dir_in)) && strobe_edge && !rx_full;
    assign tx_pop  = (st == ST_ACTIVE_IN) && !abort && !ctl_s.ready_n && !tx_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            dir_in     <= 1'b0;
            words      <= '0;
            bus_out    <= '0;
            dev_strobe <= 1'b0;
        end else begin
            st     <= st_nxt;
            dir_in <= dir_in_nxt;
            if (st == ST_REQUEST)         words <= '0;
            else if (rx_push || tx_pop)   words <= words + 1'b1;
            if (tx_pop) begin
                bus_out    <= tx_rdata;
                dev_strobe <= ~dev_strobe;
            end
        end
    end

    assign dev_req     = (st == ST_REQUEST) || (st == ST_ACTIVE_OUT) || (st == ST_ACTIVE_IN)
                       || (st == ST_PAUSED && dir_in);
    assign bus_oe      = (st == ST_ACTIVE_IN) || (st == ST_PAUSED && dir_in);
    assign burst_done  = (st == ST_TERMINATE);
    assign burst_words = words;

    AST_DONE_SINGLE:     assert property (@(posedge clk) disable iff (rst) burst_done |=> !burst_done);   // R6
    AST_DONE_REQ_LOW:    assert property (@(posedge clk) disable iff (rst) burst_done |-> !dev_req);      // R6
    AST_NEAR_FULL_PAUSE: assert property (@(posedge clk) disable iff (rst)
                             (st == ST_ACTIVE_OUT && rx_near) |=> !dev_req);                              // R8
    AST_STROBE_WITH_OE:  assert property (@(posedge clk) disable iff (rst)
                             (dev_strobe != $past(dev_strobe)) |-> bus_oe);                               // R7
    AST_NO_START_STOP:   assert property (@(posedge clk) disable iff (rst)
                             (st == ST_REQUEST && ctl_s.stop) |=> (st == ST_REQUEST || st == ST_IDLE));   // R3
endmodule

// File: tb/udma_burst_engine_tb.sv
module udma_burst_engine_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        want_rx = 1'b0, want_tx = 1'b0, rx_pop = 1'b0, tx_push = 1'b0;
    logic [15:0] tx_wdata = '0, bus_in = '0;
    logic        host_ack_n = 1'b1, host_stop = 1'b0, host_strobe = 1'b0, host_ready_n = 1'b1;
    logic [15:0] rx_data, bus_out, burst_words;
    logic        rx_avail, tx_full, bus_oe, dev_strobe, dev_req, burst_done;

    int checks = 0, fails = 0;
    int done_seen = 0;
    int last_words = 0;
    int n_got = 0;
    logic [15:0] got [16];
    logic ds_prev = 1'b0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    udma_burst_engine u_dut (
        .clk(clk), .rst(rst), .want_rx(want_rx), .want_tx(want_tx),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_avail(rx_avail),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full),
        .host_ack_n(host_ack_n), .host_stop(host_stop), .host_strobe(host_strobe),
        .host_ready_n(host_ready_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .dev_strobe(dev_strobe), .dev_req(dev_req), .burst_done(burst_done),
        .burst_words(burst_words)
    );

    // Port monitor: records sent words and done pulses
    always @(negedge clk) begin
        if (!rst && dev_strobe !== ds_prev) begin
            if (n_got < 16) got[n_got] = bus_out;
            n_got = n_got + 1;
        end
        ds_prev = dev_strobe;
        if (!rst && burst_done) begin
            done_seen  = done_seen + 1;
            last_words = int'(burst_words);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_edge(input logic [15:0] d);
        bus_in = d;
        tick(3);
        host_strobe = ~host_strobe;
        tick(4);
    endtask

    task automatic pop_rx(output logic [15:0] w);
        w = rx_data;
        rx_pop = 1'b1;
        tick(1);
        rx_pop = 1'b0;
    endtask

    task automatic push_tx(input logic [15:0] d);
        tx_wdata = d;
        tx_push  = 1'b1;
        tick(1);
        tx_push  = 1'b0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic test_reset_state;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 dev_req", int'(dev_req), 0);
        chk("R1 burst_done", int'(burst_done), 0);
        chk("R1 bus_oe", int'(bus_oe), 0);
        chk("R1 rx_avail", int'(rx_avail), 0);
        chk("R1 tx_full", int'(tx_full), 0);
    endtask

    task automatic test_receive_burst;
        logic [15:0] w;
        int d0;
        tick(5);
        chk("R2 no request without demand", int'(dev_req), 0);
        want_rx = 1'b1;
        tick(3);
        chk("R2 request on want_rx", int'(dev_req), 1);
        // R3: acknowledge under stop must not start the burst
        host_stop  = 1'b1;
        host_ack_n = 1'b0;
        tick(4);
        send_edge(16'hBEEF);
        send_edge(16'hBEEF);
        chk("R3 no capture while stop high", int'(rx_avail), 0);
        chk("R3 still requesting", int'(dev_req), 1);
        host_stop = 1'b0;
        tick(5);
        d0 = done_seen;
        for (int i = 0; i < 3; i++) send_edge(16'hA000 + 16'(i));
        // R5: strobe idle, burst held open
        tick(25);
        chk("R5 request held during strobe pause", int'(dev_req), 1);
        chk("R5 no done during pause", done_seen, d0);
        send_edge(16'hA003);
        want_rx = 1'b0;
        host_stop = 1'b1;
        tick(6);
        chk("R6 one done pulse", done_seen, d0 + 1);
        chk("R6 word count", last_words, 4);
        chk("R6 request low after stop", int'(dev_req), 0);
        host_ack_n = 1'b1;
        host_stop  = 1'b0;
        tick(2);
        for (int i = 0; i < 4; i++) begin
            pop_rx(w);
            chk("R4 word order both edges", int'(w), 16'hA000 + i);
        end
        chk("R4 fifo drained", int'(rx_avail), 0);
    endtask

    task automatic test_near_full;
        logic [15:0] w;
        want_rx = 1'b1;
        tick(3);
        host_ack_n = 1'b0;
        tick(5);
        for (int i = 0; i < 6; i++) send_edge(16'hC000 + 16'(i));
        tick(2);
        chk("R8 request drops near full", int'(dev_req), 0);
        for (int i = 6; i < 9; i++) send_edge(16'hC000 + 16'(i));
        host_stop = 1'b1;
        tick(6);
        chk("R8 full burst count, extra edge discarded", last_words, 8);
        host_ack_n = 1'b1;
        host_stop  = 1'b0;
        tick(8);
        chk("R8 no request while full", int'(dev_req), 0);
        pop_rx(w);
        chk("R8 first word", int'(w), 16'hC000);
        tick(3);
        chk("R8 request returns with room", int'(dev_req), 1);
        want_rx = 1'b0;
        tick(3);
        for (int i = 1; i < 8; i++) begin
            pop_rx(w);
            chk("R8 stored words", int'(w), 16'hC000 + i);
        end
        chk("R8 ninth word not stored", int'(rx_avail), 0);
    endtask

    task automatic test_send_burst;
        int k, d0;
        for (int i = 0; i < 8; i++) push_tx(16'h5000 + 16'(i));
        chk("R7 tx full after eight", int'(tx_full), 1);
        n_got = 0;
        d0 = done_seen;
        want_tx = 1'b1;
        tick(3);
        chk("R2 request on want_tx", int'(dev_req), 1);
        host_ack_n = 1'b0;
        tick(6);
        want_tx = 1'b0;
        chk("R7 bus driven while host not ready", int'(bus_oe), 1);
        chk("R7 no words before ready", n_got, 0);
        host_ready_n = 1'b0;
        for (int t = 0; t < 20 && n_got < 2; t++) tick(1);
        host_ready_n = 1'b1;
        tick(5);
        k = n_got;
        tick(10);
        chk("R7 strobe held while not ready", n_got, k);
        chk("R7 pause before fifo empty", int'(k < 8), 1);
        chk("R7 no done while paused", done_seen, d0);
        host_ready_n = 1'b0;
        tick(20);
        chk("R9 all words sent", n_got, 8);
        chk("R9 done on empty", done_seen, d0 + 1);
        chk("R9 word count", last_words, 8);
        for (int i = 0; i < 8; i++) chk("R7 send order", int'(got[i]), 16'h5000 + i);
        chk("R9 bus released", int'(bus_oe), 0);
        host_ack_n   = 1'b1;
        host_ready_n = 1'b1;
        tick(4);
    endtask

    task automatic test_reset_mid_burst;
        push_tx(16'h7001);
        push_tx(16'h7002);
        want_rx = 1'b1;
        tick(3);
        host_ack_n = 1'b0;
        tick(5);
        send_edge(16'h7100);
        send_edge(16'h7101);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        want_rx = 1'b0;
        host_ack_n = 1'b1;
        tick(1);
        chk("R10 request low after reset", int'(dev_req), 0);
        chk("R10 rx cleared", int'(rx_avail), 0);
        want_tx = 1'b1;
        tick(6);
        chk("R10 tx cleared, no send request", int'(dev_req), 0);
        want_tx = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        test_reset_state();
        test_receive_burst();
        test_near_full();
        test_send_burst();
        test_reset_mid_burst();
        finish_run();
    end
endmodule